// File: doc/BRIEF.md
# DMA Interrupt Status Register Block

This block keeps the interrupt state of a multi-channel DMA controller. Each channel engine reports finished transfers and failed transfers as one-cycle set pulses. The block holds them as raw pending bits, one terminal-count bit and one error bit per channel. Software reaches the state through a word-addressed register port. Pending bits are cleared by writing ones to a clear word.

Each channel has its own configuration word, and three of its bits are held here: a terminal-count enable, an error enable and the channel enable. The two interrupt enables act as masks. They produce the masked status views and three level interrupt lines: error, terminal count, and their OR. A vector of channel enables is presented both as a register and on a port. A small global configuration word is also kept here. The channel count is a parameter, for example 8 or 2.

Top module: `dma_irq_regs`

## Requirements
- R1: After reset, every raw pending bit, every per-channel configuration bit and the global configuration word are zero. All three interrupt outputs are low and `ch_enabled` is zero.
- R2: A 1 on bit i of `tc_set` (or `err_set`) sets raw bit i for channel i at that clock edge. The raw terminal-count bits read at word 5 and the raw error bits at word 6, with channel i in data bit i.
- R3: Word 1 reads raw terminal-count bits ANDed with the terminal-count mask. Word 3 reads raw error bits ANDed with the error mask. Word 0 reads the OR of words 1 and 3.
- R4: Channel i's configuration word is at word 64 + 8*i + 4. Its data bit 15 is the channel's terminal-count mask bit, bit 14 its error mask bit and bit 0 its enable. A read of that word returns exactly those three bits in place. Word 7 and the `ch_enabled` port give the enable bits with channel i in bit i.
- R5: Writing word 2 clears each raw terminal-count bit whose data bit is 1. Writing word 4 does the same for the raw error bits. Bits written as 0 keep their value.
- R6: When a set pulse and a clear write hit the same bit on the same edge, the bit ends up set.
- R7: `irq_err` is high when any masked error bit is set and `irq_tc` is high when any masked terminal-count bit is set. `irq_any` is their OR. They follow the state with no further register stage, so they react on the same edge as the state, including mask changes.
- R8: Word 12 stores the low GCFG_W bits of a write and reads them back with the upper bits zero.
- R9: A read of an unmapped word returns zero with `bad_access` high in the cycle that data is presented. Unmapped words are the clear words 2 and 4, channel words other than +4, channels at or above NUM_CH, and all others not listed here. A mapped read leaves `bad_access` low.
- R10: Writes to read-only words (0, 1, 3, 5, 6, 7) and to unmapped words change no state.
- R11: `rdata` carries the value addressed by a read one cycle after `rd_en`, and is zero in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_set | input | NUM_CH | Per-channel terminal-count set pulses |
| err_set | input | NUM_CH | Per-channel error set pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, one cycle after rd_en |
| bad_access | output | 1 | One-cycle flag for a read of an unmapped word |
| irq_err | output | 1 | Masked error interrupt level |
| irq_tc | output | 1 | Masked terminal-count interrupt level |
| irq_any | output | 1 | OR of the two interrupt levels |
| ch_enabled | output | NUM_CH | Per-channel enable bits |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high together. They also assume that `wdata` and `addr` are known whenever a strobe is high, and that set pulses last one cycle. The stimulus drives every strobe on the falling clock edge with exactly one operation per cycle. The only overlap it creates is the deliberate one of a set pulse with a clear write. Between operations the bus inputs return to zero.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   // word offsets of the status window
   localparam int OFS_ALL     = 0;
   localparam int OFS_TC_MSK  = 1;
   localparam int OFS_TC_CLR  = 2;
   localparam int OFS_ER_MSK  = 3;
   localparam int OFS_ER_CLR  = 4;
   localparam int OFS_TC_RAW  = 5;
   localparam int OFS_ER_RAW  = 6;
   localparam int OFS_ENA     = 7;
   localparam int OFS_GCFG    = 12;
   // per-channel window: base + stride*ch + sub
   localparam int CH_BASE     = 64;
   localparam int CH_STRIDE   = 8;
   localparam int CH_CFG_SUB  = 4;
   localparam int CH_MAX      = 8;
   // channel configuration bit positions
   localparam int CB_EN       = 0;
   localparam int CB_IE       = 14;
   localparam int CB_ITC      = 15;

   function automatic int chan_cfg_word(input int ch);
      return CH_BASE + CH_STRIDE * ch + CH_CFG_SUB;
   endfunction
endpackage

// File: rtl/dma_irq_pending.sv
module dma_irq_pending #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] set_i,
   input  logic              clr_we,
   input  logic [NUM_CH-1:0] clr_bits,
   output logic [NUM_CH-1:0] raw_o
);
   logic [NUM_CH-1:0] clr_eff;

   always_comb clr_eff = clr_we ? clr_bits : '0;

   // set has priority over clear on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_o <= '0;
      else        raw_o <= (raw_o & ~clr_eff) | set_i;
   end
endmodule

// File: rtl/dma_irq_chcfg.sv
module dma_irq_chcfg
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] en_o,
   output logic [NUM_CH-1:0] ie_o,
   output logic [NUM_CH-1:0] itc_o
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] MY_WORD = ADDR_W'(chan_cfg_word(g));
      logic hit;
      always_comb hit = wr_en && (addr == MY_WORD);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_o[g]  <= 1'b0;
            ie_o[g]  <= 1'b0;
            itc_o[g] <= 1'b0;
         end else if (hit) begin
            en_o[g]  <= wdata[CB_EN];
            ie_o[g]  <= wdata[CB_IE];
            itc_o[g] <= wdata[CB_ITC];
         end
      end
   end
endmodule

// File: rtl/dma_irq_rdmux.sv
module dma_irq_rdmux
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int GCFG_W = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [NUM_CH-1:0] raw_tc,
   input  logic [NUM_CH-1:0] raw_err,
   input  logic [NUM_CH-1:0] msk_tc,
   input  logic [NUM_CH-1:0] msk_err,
   input  logic [NUM_CH-1:0] en,
   input  logic [NUM_CH-1:0] ie,
   input  logic [NUM_CH-1:0] itc,
   input  logic [GCFG_W-1:0] gcfg,
   output logic [DATA_W-1:0] value,
   output logic              mapped
);
   localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(CH_BASE);
   localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(CH_BASE + CH_STRIDE * CH_MAX);

   always_comb begin
      value  = '0;
      mapped = 1'b0;
      if (addr >= WIN_LO && addr < WIN_HI) begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(chan_cfg_word(i))) begin
               mapped        = 1'b1;
               value[CB_EN]  = en[i];
               value[CB_IE]  = ie[i];
               value[CB_ITC] = itc[i];
            end
         end
      end else begin
         case (addr)
            ADDR_W'(OFS_ALL):    begin mapped = 1'b1; value[NUM_CH-1:0] = msk_tc | msk_err; end
            ADDR_W'(OFS_TC_MSK): begin mapped = 1'b1; value[NUM_CH-1:0] = msk_tc;           end
            ADDR_W'(OFS_ER_MSK): begin mapped = 1'b1; value[NUM_CH-1:0] = msk_err;          end
            ADDR_W'(OFS_TC_RAW): begin mapped = 1'b1; value[NUM_CH-1:0] = raw_tc;           end
            ADDR_W'(OFS_ER_RAW): begin mapped = 1'b1; value[NUM_CH-1:0] = raw_err;          end
            ADDR_W'(OFS_ENA):    begin mapped = 1'b1; value[NUM_CH-1:0] = en;               end
            ADDR_W'(OFS_GCFG):   begin mapped = 1'b1; value[GCFG_W-1:0] = gcfg;             end
            default:             begin mapped = 1'b0; value = '0;                           end
         endcase
      end
   end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int GCFG_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tc_set,
   input  logic [NUM_CH-1:0] err_set,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              bad_access,
   output logic              irq_err,
   output logic              irq_tc,
   output logic              irq_any,
   output logic [NUM_CH-1:0] ch_enabled
);
   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > CH_MAX) begin : g_bad_nch
      $error("NUM_CH must be 1..%0d", CH_MAX);
   end
   if (ADDR_W < 7) begin : g_bad_aw
      $error("ADDR_W too narrow for the channel window");
   end
   if (DATA_W < 16) begin : g_bad_dw
      $error("DATA_W must hold the channel configuration bits");
   end
   if (GCFG_W < 1 || GCFG_W > DATA_W) begin : g_bad_gw
      $error("GCFG_W out of range");
   end

   logic [NUM_CH-1:0] raw_tc, raw_err, msk_tc, msk_err;
   logic [NUM_CH-1:0] cfg_en, cfg_ie, cfg_itc;
   logic [GCFG_W-1:0] gcfg_q;
   logic [DATA_W-1:0] rd_val;
   logic              rd_ok;
   logic              clr_tc_we, clr_er_we;

   always_comb begin
      clr_tc_we = wr_en && (addr == ADDR_W'(OFS_TC_CLR));
      clr_er_we = wr_en && (addr == ADDR_W'(OFS_ER_CLR));
   end

   dma_irq_pending #(.NUM_CH(NUM_CH)) u_tc (
      .clk(clk), .rst_n(rst_n), .set_i(tc_set), .clr_we(clr_tc_we),
      .clr_bits(wdata[NUM_CH-1:0]), .raw_o(raw_tc)
   );

   dma_irq_pending #(.NUM_CH(NUM_CH)) u_er (
      .clk(clk), .rst_n(rst_n), .set_i(err_set), .clr_we(clr_er_we),
      .clr_bits(wdata[NUM_CH-1:0]), .raw_o(raw_err)
   );

   dma_irq_chcfg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .en_o(cfg_en), .ie_o(cfg_ie), .itc_o(cfg_itc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    gcfg_q <= '0;
      else if (wr_en && addr == ADDR_W'(OFS_GCFG))   gcfg_q <= wdata[GCFG_W-1:0];
   end

   always_comb begin
      msk_tc  = raw_tc & cfg_itc;
      msk_err = raw_err & cfg_ie;
   end

   dma_irq_rdmux #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GCFG_W(GCFG_W)) u_rd (
      .addr(addr), .raw_tc(raw_tc), .raw_err(raw_err), .msk_tc(msk_tc),
      .msk_err(msk_err), .en(cfg_en), .ie(cfg_ie), .itc(cfg_itc),
      .gcfg(gcfg_q), .value(rd_val), .mapped(rd_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata      <= '0;
         bad_access <= 1'b0;
      end else begin
         rdata      <= rd_en ? rd_val : '0;
         bad_access <= rd_en && !rd_ok;
      end
   end

   always_comb begin
      irq_tc     = |msk_tc;
      irq_err    = |msk_err;
      irq_any    = irq_tc | irq_err;
      ch_enabled = cfg_en;
   end
endmodule

// File: rtl/dma_irq_chk.sv
module dma_irq_chk #(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] tc_set,
   input logic [NUM_CH-1:0] err_set,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DATA_W-1:0] rdata,
   input logic              bad_access,
   input logic              irq_err,
   input logic              irq_tc,
   input logic              irq_any,
   input logic [NUM_CH-1:0] raw_tc,
   input logic [NUM_CH-1:0] raw_err
);
   localparam logic [ADDR_W-1:0] A_TC_CLR = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_ER_CLR = ADDR_W'(4);

   p_set_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_set) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));

   p_err_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_set) |=> ((raw_err & $past(err_set)) == $past(err_set)));

   p_tc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_TC_CLR && tc_set == '0)
      |=> ((raw_tc & $past(wdata[NUM_CH-1:0])) == '0));

   p_er_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_ER_CLR && err_set == '0)
      |=> ((raw_err & $past(wdata[NUM_CH-1:0])) == '0));

   p_tc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && addr == A_TC_CLR) && tc_set == '0) |=> $stable(raw_tc));

   p_bad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bad_access |-> (rdata == '0));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0 && !bad_access));

   p_any_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_any |-> (!irq_tc && !irq_err));

   p_no_raw_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_tc == '0 && raw_err == '0) |-> !irq_any);
endmodule

bind dma_irq_regs dma_irq_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tc_set(tc_set), .err_set(err_set),
   .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .bad_access(bad_access), .irq_err(irq_err),
   .irq_tc(irq_tc), .irq_any(irq_any), .raw_tc(raw_tc), .raw_err(raw_err)
);

// File: tb/sim_dma_irq_regs.sv
`timescale 1ns/1ps
module sim_dma_irq_regs;
   localparam int NCH = 8;
   localparam int AW  = 10;
   localparam int DW  = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] tc_set = '0, err_set = '0;
   logic           wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [DW-1:0]  wdata = '0;
   logic [DW-1:0]  rdata;
   logic           bad_access, irq_err, irq_tc, irq_any;
   logic [NCH-1:0] ch_enabled;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dma_irq_regs #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .GCFG_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .tc_set(tc_set), .err_set(err_set),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .bad_access(bad_access), .irq_err(irq_err),
      .irq_tc(irq_tc), .irq_any(irq_any), .ch_enabled(ch_enabled)
   );

   // entry: op[79:78] 1=write 2=read-check 3=pulse(tc=data[7:0], err=data[15:8])
   //        addr[77:68] data[67:36] expect[35:4] req[3:0]
   localparam int NV = 27;
   localparam logic [79:0] VEC [NV] = '{
      {2'd1, 10'd68,  32'h0000C001, 32'h0, 4'd4},  // R4 ch0: itc, ie, en
      {2'd1, 10'd92,  32'h00008000, 32'h0, 4'd4},  // R4 ch3: itc
      {2'd1, 10'd108, 32'hFFFF4001, 32'h0, 4'd4},  // R4 ch5: ie, en
      {2'd2, 10'd7,   32'h0, 32'h00000021, 4'd4},  // R4 enable vector
      {2'd2, 10'd68,  32'h0, 32'h0000C001, 4'd4},  // R4
      {2'd2, 10'd92,  32'h0, 32'h00008000, 4'd4},  // R4
      {2'd2, 10'd108, 32'h0, 32'h00004001, 4'd4},  // R4
      {2'd1, 10'd12,  32'hFFFFFFFF, 32'h0, 4'd8},  // R8
      {2'd2, 10'd12,  32'h0, 32'h00000007, 4'd8},  // R8
      {2'd1, 10'd5,   32'hFFFFFFFF, 32'h0, 4'd10}, // R10 read-only word
      {2'd2, 10'd5,   32'h0, 32'h00000000, 4'd10}, // R10
      {2'd3, 10'd0,   32'h00002409, 32'h0, 4'd2},  // R2 tc ch0,ch3 err ch2,ch5
      {2'd2, 10'd5,   32'h0, 32'h00000009, 4'd2},  // R2
      {2'd2, 10'd6,   32'h0, 32'h00000024, 4'd2},  // R2
      {2'd2, 10'd1,   32'h0, 32'h00000009, 4'd3},  // R3
      {2'd2, 10'd3,   32'h0, 32'h00000020, 4'd3},  // R3
      {2'd2, 10'd0,   32'h0, 32'h00000029, 4'd3},  // R3
      {2'd1, 10'd2,   32'h00000001, 32'h0, 4'd5},  // R5 clear tc ch0
      {2'd2, 10'd5,   32'h0, 32'h00000008, 4'd5},  // R5
      {2'd2, 10'd1,   32'h0, 32'h00000008, 4'd5},  // R5
      {2'd1, 10'd4,   32'h00000020, 32'h0, 4'd5},  // R5 clear err ch5
      {2'd2, 10'd6,   32'h0, 32'h00000004, 4'd5},  // R5
      {2'd2, 10'd3,   32'h0, 32'h00000000, 4'd5},  // R5
      {2'd2, 10'd0,   32'h0, 32'h00000008, 4'd3},  // R3
      {2'd1, 10'd1,   32'hFFFFFFFF, 32'h0, 4'd10}, // R10
      {2'd1, 10'd300, 32'hFFFFFFFF, 32'h0, 4'd10}, // R10 unmapped write
      {2'd2, 10'd5,   32'h0, 32'h00000008, 4'd10}  // R10
   };

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wdata = '0;
   endtask

   // returns rdata and bad_access sampled in the cycle after the strobe
   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic b);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      d = rdata; b = bad_access;
      rd_en = 1'b0; addr = '0;
   endtask

   task automatic do_pulse(input logic [NCH-1:0] t, input logic [NCH-1:0] e);
      @(negedge clk);
      tc_set = t; err_set = e;
      @(negedge clk);
      tc_set = '0; err_set = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      logic          b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      chk("R1 irq_any", {31'b0, irq_any}, 32'h0);
      chk("R1 ch_enabled", {24'b0, ch_enabled}, 32'h0);
      do_read(10'd5, d, b);  chk("R1 raw tc", d, 32'h0);
      do_read(10'd6, d, b);  chk("R1 raw err", d, 32'h0);
      do_read(10'd12, d, b); chk("R1 gcfg", d, 32'h0);
      chk("R11 mapped read not flagged", {31'b0, b}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         logic [1:0]    op;
         logic [AW-1:0] a;
         logic [DW-1:0] dat, ex;
         op = VEC[k][79:78]; a = VEC[k][77:68]; dat = VEC[k][67:36]; ex = VEC[k][35:4];
         case (op)
            2'd1: do_write(a, dat);
            2'd3: do_pulse(dat[7:0], dat[15:8]);
            default: begin
               do_read(a, d, b);
               chk($sformatf("R%0d vec%0d addr=%0d", VEC[k][3:0], k, a), d, ex);
            end
         endcase
      end

      // R4 enable port, R7 levels: tc raw ch3 masked, err raw ch2 unmasked
      chk("R4 ch_enabled port", {24'b0, ch_enabled}, 32'h21);
      chk("R7 irq_tc", {31'b0, irq_tc}, 32'h1);
      chk("R7 irq_err", {31'b0, irq_err}, 32'h0);
      chk("R7 irq_any", {31'b0, irq_any}, 32'h1);

      // R6 set ch1 and clear ch1,ch3 on the same edge
      @(negedge clk);
      tc_set = 8'h02; wr_en = 1'b1; addr = 10'd2; wdata = 32'h0000000A;
      @(negedge clk);
      tc_set = '0; wr_en = 1'b0; addr = '0; wdata = '0;
      chk("R7 irq_tc after mask-out", {31'b0, irq_tc}, 32'h0);
      chk("R7 irq_any low", {31'b0, irq_any}, 32'h0);
      do_read(10'd5, d, b); chk("R6 set beats clear", d, 32'h2);

      // R9 unmapped reads
      do_read(10'd2, d, b);
      chk("R9 clear word rdata", d, 32'h0);
      chk("R9 clear word flag", {31'b0, b}, 32'h1);
      @(negedge clk);
      chk("R9 flag lasts one cycle", {31'b0, bad_access}, 32'h0);
      chk("R11 idle rdata", rdata, 32'h0);
      do_read(10'd69, d, b);
      chk("R9 channel sub-word flag", {31'b0, b}, 32'h1);
      do_read(10'd6, d, b);
      chk("R9 mapped read flag", {31'b0, b}, 32'h0);

      // R7 mask change alone raises the error line (ch2 err pending)
      do_write(10'd84, 32'h00004000);
      chk("R7 irq_err after mask-in", {31'b0, irq_err}, 32'h1);
      chk("R7 irq_any after mask-in", {31'b0, irq_any}, 32'h1);

      // R1 reset in mid-run
      do_pulse(8'hFF, 8'hFF);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 irq_any in reset", {31'b0, irq_any}, 32'h0);
      rst_n = 1'b1;
      do_read(10'd5, d, b);  chk("R1 raw tc after reset", d, 32'h0);
      do_read(10'd6, d, b);  chk("R1 raw err after reset", d, 32'h0);
      do_read(10'd7, d, b);  chk("R1 enables after reset", d, 32'h0);
      do_read(10'd12, d, b); chk("R1 gcfg after reset", d, 32'h0);
      do_read(10'd84, d, b); chk("R1 ch2 cfg after reset", d, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule